// File: doc/BRIEF.md
# Frame-Locked Clock and Enable Generator

This block runs on a fast master clock and watches an active-low 8 kHz frame pulse. From these it produces a half-rate derived clock, two channel-enable windows, a one-cycle frame-start strobe and a ready flag. After power-down is released, every output stays quiet until the first valid frame pulse arrives. From then on the frame pulse is supervised continuously. A pulse that stays low too long freezes the derived clock low. A pulse held high lets the clock run on. In bus-timed mode, the enables go silent in any frame that brings no new pulse.

The block also measures the length of each frame in master-clock cycles. It raises the ready flag only when the frame just ended held enough cycles for the downstream processing engine. Frames longer than the minimum are accepted, because every frame realigns on its own pulse.

Top module: `fsync_clkgen`

## Requirements
- R1: After reset, `ck_o`, `en1_o`, `en2_o`, `frm_o` and `rdy_o` are 0, and they stay 0 until the first frame start, even while `fp_n_i` is held high.
- R2: A frame start is the clock edge at which `fp_n_i` is sampled 0 after being sampled 1 at the previous edge. `frm_o` is 1 for exactly the one cycle that follows that edge.
- R3: At each frame start `ck_o` is set to 1. After that it inverts on every master-clock edge while it is running, so it runs at half the master-clock rate.
- R4: When `fp_n_i` is sampled low at more than LOW_MAX (2) consecutive edges, `ck_o` is forced to 0 at the edge of the (LOW_MAX+1)th low sample. It stays 0 until the next frame start. A low pulse of 1 or 2 samples does not stop the clock.
- R5: While `fp_n_i` is held high after lock, `ck_o` keeps toggling.
- R6: A frame position counter is 0 in the cycle after a frame start, increments each cycle and wraps from FRAME_CYC-1 to 0. While the enables are active, `en1_o` is 1 for positions 0 to EN_LEN-1 and `en2_o` is 1 for positions EN_LEN to 2*EN_LEN-1. Both are never 1 at once.
- R7: With `mode_i`=1 (bus-timed), if the position wraps to 0 without a frame start at that edge, both enables are held at 0 until the next frame start.
- R8: With `mode_i`=0 (strobe-timed), the enable windows repeat every FRAME_CYC cycles without any new pulse.
- R9: At every frame start except the first after reset, `rdy_o` is set to 1 if the frame that just ended lasted at least MIN_CYC master cycles, and to 0 otherwise. `rdy_o` holds its value between frame starts.
- R10: `rst_ni` is active low and asynchronous: asserting it drives all outputs to 0 without waiting for a clock edge. Its release is synchronized to the master clock through two flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset / power-down |
| fp_n_i | input | 1 | Active-low frame pulse |
| mode_i | input | 1 | 0 = strobe-timed, 1 = bus-timed |
| ck_o | output | 1 | Derived half-rate clock |
| en1_o | output | 1 | First channel enable window |
| en2_o | output | 1 | Second channel enable window |
| frm_o | output | 1 | One-cycle frame-start strobe |
| rdy_o | output | 1 | Previous frame held at least MIN_CYC cycles |

## Verification
The bench builds the block with FRAME_CYC=32, MIN_CYC=24, EN_LEN=4, LOW_MAX=2 and CNT_W=8. The short frame lets one run cover many frames. It brings the ready threshold within reach from both sides, with frames of exactly 24 and 23 cycles. It also makes the bus-timed silence and the strobe-timed free-run visible within 80 cycles of a missing pulse. The 2-cycle low limit is exercised with a 2-sample pulse, which must keep the clock running, and a 5-sample hold, which must freeze it.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [0:0] {
        MODE_STROBE = 1'b0,
        MODE_BUS    = 1'b1
    } frame_mode_e;

    typedef struct packed {
        logic locked;
        logic run;
        logic ck;
        logic en_on;
        logic frm;
        logic rdy;
        logic have_prev;
    } gen_state_t;

endpackage

// File: rtl/fsg_rst_sync.sv
module fsg_rst_sync (
    input  logic clk_i,
    input  logic rst_ni,
    output logic rst_no
);
    logic [1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[0], 1'b1};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= 2'b00;
        else         sync_q <= sync_d;
    end

    assign rst_no = sync_q[1];
endmodule

// File: rtl/fsg_pulse_mon.sv
module fsg_pulse_mon #(
    parameter int LOW_MAX = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fp_n_i,
    output logic start_o,
    output logic stall_o
);
    localparam int LW = $clog2(LOW_MAX + 1);

    typedef struct packed {
        logic          prev;
        logic [LW-1:0] lowc;
    } mon_state_t;

    mon_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = fp_n_i;
        if (fp_n_i)                      s_d.lowc = '0;
        else if (s_q.lowc != LW'(LOW_MAX)) s_d.lowc = s_q.lowc + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{prev: 1'b1, lowc: '0};
        else         s_q <= s_d;
    end

    assign start_o = s_q.prev & ~fp_n_i;
    assign stall_o = ~fp_n_i & (s_q.lowc == LW'(LOW_MAX));
endmodule

// File: rtl/fsg_frame_ctr.sv
module fsg_frame_ctr #(
    parameter int FRAME_CYC = 512,
    parameter int CNT_W     = 10
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         run_i,
    input  logic                         start_i,
    output logic [$clog2(FRAME_CYC)-1:0] pos_o,
    output logic [CNT_W-1:0]             len_o,
    output logic                         wrap_o
);
    localparam int PW = $clog2(FRAME_CYC);
    localparam logic [PW-1:0] POS_LAST = PW'(FRAME_CYC - 1);

    typedef struct packed {
        logic [PW-1:0]    pos;
        logic [CNT_W-1:0] len;
    } ctr_state_t;

    ctr_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start_i) begin
            s_d.pos = '0;
            s_d.len = '0;
        end else if (run_i) begin
            s_d.pos = (s_q.pos == POS_LAST) ? '0 : s_q.pos + 1'b1;
            if (s_q.len != '1) s_d.len = s_q.len + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign pos_o  = s_q.pos;
    assign len_o  = s_q.len;
    assign wrap_o = run_i & ~start_i & (s_q.pos == POS_LAST);
endmodule

// File: rtl/fsync_clkgen.sv
module fsync_clkgen
    import fsg_pkg::*;
#(
    parameter int FRAME_CYC = 512,
    parameter int MIN_CYC   = 512,
    parameter int EN_LEN    = 32,
    parameter int LOW_MAX   = 2,
    parameter int CNT_W     = 10
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fp_n_i,
    input  logic mode_i,
    output logic ck_o,
    output logic en1_o,
    output logic en2_o,
    output logic frm_o,
    output logic rdy_o
);
    localparam int PW = $clog2(FRAME_CYC);
    localparam logic [CNT_W-1:0] LEN_OK = CNT_W'(MIN_CYC - 1);

    logic             rst_core_n;
    logic             start, stall, wrap;
    logic [PW-1:0]    pos;
    logic [CNT_W-1:0] len;
    gen_state_t       s_d, s_q;

    fsg_rst_sync u_rst (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .rst_no (rst_core_n)
    );

    fsg_pulse_mon #(.LOW_MAX(LOW_MAX)) u_mon (
        .clk_i   (clk_i),
        .rst_ni  (rst_core_n),
        .fp_n_i  (fp_n_i),
        .start_o (start),
        .stall_o (stall)
    );

    fsg_frame_ctr #(.FRAME_CYC(FRAME_CYC), .CNT_W(CNT_W)) u_ctr (
        .clk_i   (clk_i),
        .rst_ni  (rst_core_n),
        .run_i   (s_q.locked),
        .start_i (start),
        .pos_o   (pos),
        .len_o   (len),
        .wrap_o  (wrap)
    );

    always_comb begin
        s_d     = s_q;
        s_d.frm = start;
        if (start) begin
            s_d.locked    = 1'b1;
            s_d.run       = 1'b1;
            s_d.ck        = 1'b1;
            s_d.en_on     = 1'b1;
            s_d.have_prev = 1'b1;
            s_d.rdy       = s_q.have_prev & (len >= LEN_OK);
        end else begin
            if (s_q.run) s_d.ck = ~s_q.ck;
            if (stall) begin
                s_d.run = 1'b0;
                s_d.ck  = 1'b0;
            end
            if (frame_mode_e'(mode_i) == MODE_BUS && wrap) s_d.en_on = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_core_n) begin
        if (!rst_core_n) s_q <= '0;
        else             s_q <= s_d;
    end

    assign ck_o  = s_q.ck;
    assign frm_o = s_q.frm;
    assign rdy_o = s_q.rdy;
    assign en1_o = s_q.en_on & (int'(pos) < EN_LEN);
    assign en2_o = s_q.en_on & (int'(pos) >= EN_LEN) & (int'(pos) < 2 * EN_LEN);
endmodule

// File: rtl/fsync_clkgen_chk.sv
module fsync_clkgen_chk #(
    parameter int LOW_MAX = 2
) (
    input logic clk_i,
    input logic rst_core_n,
    input logic fp_n_i,
    input logic ck_o,
    input logic en1_o,
    input logic en2_o,
    input logic frm_o
);
    logic seen_q;
    int   low_q;

    always_ff @(posedge clk_i or negedge rst_core_n) begin
        if (!rst_core_n) begin
            seen_q <= 1'b0;
            low_q  <= 0;
        end else begin
            if (frm_o) seen_q <= 1'b1;
            low_q <= fp_n_i ? 0 : ((low_q < LOW_MAX + 1) ? low_q + 1 : low_q);
        end
    end

    AST_IDLE_BEFORE_LOCK: assert property (@(posedge clk_i) disable iff (!rst_core_n)
        (!seen_q && !frm_o) |-> (!ck_o && !en1_o && !en2_o)); // R1

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_core_n)
        frm_o |=> !frm_o); // R2

    AST_CK_HIGH_AT_START: assert property (@(posedge clk_i) disable iff (!rst_core_n)
        frm_o |-> ck_o); // R3

    AST_CK_NO_DOUBLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_core_n)
        ck_o |=> (!ck_o || frm_o)); // R3

    AST_CK_FROZEN_LOW: assert property (@(posedge clk_i) disable iff (!rst_core_n)
        (low_q >= LOW_MAX && !fp_n_i) |=> !ck_o); // R4

    AST_EN_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_core_n)
        !(en1_o && en2_o)); // R6
endmodule

bind fsync_clkgen fsync_clkgen_chk #(.LOW_MAX(LOW_MAX)) u_chk (
    .clk_i      (clk_i),
    .rst_core_n (rst_core_n),
    .fp_n_i     (fp_n_i),
    .ck_o       (ck_o),
    .en1_o      (en1_o),
    .en2_o      (en2_o),
    .frm_o      (frm_o)
);

// File: tb/tb_fsync_clkgen.sv
module tb_fsync_clkgen;
    localparam int FRAME = 32;
    localparam int MINC  = 24;
    localparam int ENL   = 4;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic fp_n = 1'b1;
    logic mode = 1'b1;
    logic ck, en1, en2, frm, rdy;

    always #5 clk = ~clk;

    fsync_clkgen #(.FRAME_CYC(FRAME), .MIN_CYC(MINC), .EN_LEN(ENL),
                   .LOW_MAX(2), .CNT_W(8)) dut (
        .clk_i(clk), .rst_ni(rst_ni), .fp_n_i(fp_n), .mode_i(mode),
        .ck_o(ck), .en1_o(en1), .en2_o(en2), .frm_o(frm), .rdy_o(rdy));

    typedef struct {
        bit    ck, en1, en2, frm, rdy;
        string req;
    } exp_t;

    exp_t  sb[$];
    int    checks = 0;
    int    errors = 0;
    string phase  = "R1";

    // reference state, derived from the requirements
    bit m_locked, m_run, m_ck, m_en_on, m_have_prev, m_rdy, m_frm, m_prev_fp, m_mode;
    int since, lowrun;

    function automatic void model_reset();
        m_locked = 0; m_run = 0; m_ck = 0; m_en_on = 0; m_have_prev = 0;
        m_rdy = 0; m_frm = 0; m_prev_fp = 1; since = 0; lowrun = 0;
    endfunction

    task automatic check_bit(input string req, input string name, input bit got, input bit exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %b expected %b at %0t", req, name, got, exp, $time);
        end
    endtask

    task automatic step(input bit fp);
        bit   start;
        int   pos;
        exp_t e;
        @(negedge clk);
        fp_n = fp;
        mode = m_mode;
        start = m_prev_fp && !fp;
        lowrun = fp ? 0 : lowrun + 1;
        if (start) begin
            m_rdy = m_have_prev && (since + 1 >= MINC);
            m_have_prev = 1; since = 0;
            m_locked = 1; m_run = 1; m_ck = 1; m_en_on = 1; m_frm = 1;
        end else begin
            m_frm = 0;
            if (m_locked) since++;
            if (m_run) m_ck = !m_ck;
            if (lowrun >= 3) begin m_run = 0; m_ck = 0; end
            if (m_mode && m_locked && since > 0 && (since % FRAME) == 0) m_en_on = 0;
        end
        m_prev_fp = fp;
        pos = since % FRAME;
        e.ck  = m_ck;
        e.en1 = m_en_on && pos < ENL;
        e.en2 = m_en_on && pos >= ENL && pos < 2 * ENL;
        e.frm = m_frm;
        e.rdy = m_rdy;
        e.req = phase;
        sb.push_back(e);
    endtask

    task automatic idle(input int n, input bit fp);
        for (int i = 0; i < n; i++) step(fp);
    endtask

    task automatic frame(input int len, input int low);
        for (int i = 0; i < len; i++) step(i < low ? 1'b0 : 1'b1);
    endtask

    // monitor: compare each expected item one unit after its edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check_bit(e.req, "ck_o",  ck,  e.ck);
                check_bit(e.req, "en1_o", en1, e.en1);
                check_bit(e.req, "en2_o", en2, e.en2);
                check_bit(e.req, "frm_o", frm, e.frm);
                check_bit(e.req, "rdy_o", rdy, e.rdy);
            end
        end
    end

    bit done = 0;
    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        m_mode = 1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_bit("R1", "ck_o", ck, 0);
        check_bit("R1", "en1_o", en1, 0);
        check_bit("R1", "rdy_o", rdy, 0);
        rst_ni = 1'b1;
        phase = "R1"; idle(10, 1'b1);
        phase = "R2 R3 R6"; frame(32, 1); frame(32, 1); frame(32, 1);
        phase = "R9"; frame(24, 1); frame(23, 1); frame(32, 1); frame(32, 1);
        phase = "R7 R5"; idle(80, 1'b1);
        phase = "R8"; frame(32, 1); m_mode = 0; idle(80, 1'b1);
        m_mode = 1;
        phase = "R4"; frame(32, 1); idle(5, 1'b0); idle(10, 1'b1);
        phase = "R4 two-sample pulse"; frame(32, 2); frame(32, 2); frame(16, 2);
        // R10: asynchronous assertion clears outputs before any edge
        @(posedge clk);
        #3 rst_ni = 1'b0;
        #1;
        check_bit("R10", "ck_o", ck, 0);
        check_bit("R10", "en1_o", en1, 0);
        check_bit("R10", "en2_o", en2, 0);
        check_bit("R10", "frm_o", frm, 0);
        check_bit("R10", "rdy_o", rdy, 0);
        model_reset();
        @(negedge clk);
        @(negedge clk);
        rst_ni = 1'b1;
        phase = "R10 R1"; idle(8, 1'b1);
        phase = "R10 R9"; frame(32, 1); frame(32, 1); frame(8, 1);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule